// File: doc/BRIEF.md
# Three-Voice Synthesizer Register Bus

This block is the byte-wide register front end of a three-voice sound synthesizer. A host writes bytes to a 5-bit address space. The block decodes each write into the per-voice fields: oscillator frequency, pulse width, control byte, attack/decay rates and sustain/release settings. It also decodes the shared fields: filter cutoff, resonance, voice routing, voice-3 mute, filter mode and master volume. All decoded fields are held in registers and driven out as ports, where the oscillators, envelopes and filter pick them up.

Only two locations carry live data on a read. These are the voice-3 oscillator top byte and the voice-3 envelope level, and both arrive on input ports. Two further locations always read as zero. A read of any other location returns the most recent byte written to any address. That held byte lives only for a fixed number of clock cycles after the write and then reads as zero. Every write starts the lifetime again.

Top module: `voice_reg_bus`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every field output and the held readback byte become zero.
- R2: Voice v (0 to 2) occupies addresses 7v to 7v+6, and the offset selects the field. Offset 0 is frequency bits 7:0 and offset 1 is frequency bits 15:8. Offset 2 is pulse width bits 7:0, and offset 3 is pulse width bits 11:8, taken from data bits 3:0. Offset 4 is the control byte, offset 5 the attack/decay byte and offset 6 the sustain/release byte. Voice v drives bits [v*W +: W] of each packed voice output, where W is the field width.
- R3: A write updates only the addressed field bits, and the new value is visible after the rising edge that samples `wr_en`. Without a write, every field holds its value.
- R4: The 11-bit cutoff takes bits 2:0 from data bits 2:0 at address 0x15, and bits 10:3 from the whole byte at address 0x16.
- R5: At address 0x17, data bits 7:4 go to resonance and bits 3:0 to the routing enables. At address 0x18, bit 7 goes to voice-3 mute, bits 6:4 to filter mode and bits 3:0 to volume.
- R6: Writes to addresses 0x19 to 0x1F change no field output, but they do update the held readback byte.
- R7: With `rd_en` high, addresses 0x19 and 0x1A read 0x00, address 0x1B reads `osc3_in` and address 0x1C reads `env3_in`, in the same cycle.
- R8: With `rd_en` high, every other address reads the held byte, which is the last byte written to any address. With `rd_en` low, `rd_data` is 0x00. Read data is combinational from `addr`.
- R9: The held byte stays readable for HOLD_CYCLES-1 rising edges after the edge that captured the write, and reads 0x00 from the HOLD_CYCLES-th edge on. HOLD_CYCLES defaults to 0x2000. A write to any address, used or unused, restarts this window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 5 | Register address for reads and writes |
| wdata | input | 8 | Write data byte |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Read data, combinational |
| osc3_in | input | 8 | Voice-3 oscillator top byte for readback |
| env3_in | input | 8 | Voice-3 envelope level for readback |
| v_freq | output | 48 | Packed 16-bit frequency per voice |
| v_pw | output | 36 | Packed 12-bit pulse width per voice |
| v_ctrl | output | 24 | Packed control byte per voice |
| v_atk_dec | output | 24 | Packed attack/decay byte per voice |
| v_sus_rel | output | 24 | Packed sustain/release byte per voice |
| cutoff | output | 11 | Filter cutoff |
| resonance | output | 4 | Filter resonance |
| route_en | output | 4 | Voice-to-filter routing enables |
| v3_mute | output | 1 | Voice-3 mute |
| filt_mode | output | 3 | Filter mode select |
| volume | output | 4 | Master volume |

## Verification
Field outputs and the held byte change one rising edge after the write is sampled. Read data follows `addr` and `rd_en` in the same cycle. The held byte clears exactly HOLD_CYCLES edges after its write. The bench drives inputs on falling edges and samples one nanosecond later, so each write has passed exactly one capture edge before it is checked. The expiry checks count falling edges from that point, one edge before the deadline and one edge at it, and the same count is repeated after a write to an unused address has restarted the window.

// File: rtl/vrb_pkg.sv
// Shared constants and types for the voice register bus.
// Assumes three voices of seven registers each, with the global registers
// placed directly after the voice block.
package vrb_pkg;
    localparam int NUM_VOICES     = 3;
    localparam int REGS_PER_VOICE = 7;
    localparam int ADDR_W         = 5;
    localparam int DATA_W         = 8;
    localparam int FREQ_W         = 16;
    localparam int PW_W           = 12;
    localparam int CUT_W          = 11;
    localparam int CUT_LO_W       = 3;
    localparam int HOLD_DEFAULT   = 32'h2000;
    localparam int HOLD_CNT_W     = $clog2(HOLD_DEFAULT + 1);

    localparam int GLOB_BASE = NUM_VOICES * REGS_PER_VOICE;

    localparam logic [ADDR_W-1:0] A_CUT_LO    = ADDR_W'(GLOB_BASE);
    localparam logic [ADDR_W-1:0] A_CUT_HI    = ADDR_W'(GLOB_BASE + 1);
    localparam logic [ADDR_W-1:0] A_RES_ROUTE = ADDR_W'(GLOB_BASE + 2);
    localparam logic [ADDR_W-1:0] A_MODE_VOL  = ADDR_W'(GLOB_BASE + 3);
    localparam logic [ADDR_W-1:0] A_ZERO0     = ADDR_W'(GLOB_BASE + 4);
    localparam logic [ADDR_W-1:0] A_ZERO1     = ADDR_W'(GLOB_BASE + 5);
    localparam logic [ADDR_W-1:0] A_OSC3      = ADDR_W'(GLOB_BASE + 6);
    localparam logic [ADDR_W-1:0] A_ENV3      = ADDR_W'(GLOB_BASE + 7);

    typedef enum logic [2:0] {
        OFS_FREQ_LO = 3'd0,
        OFS_FREQ_HI = 3'd1,
        OFS_PW_LO   = 3'd2,
        OFS_PW_HI   = 3'd3,
        OFS_CTRL    = 3'd4,
        OFS_ATK_DEC = 3'd5,
        OFS_SUS_REL = 3'd6
    } voice_ofs_e;
endpackage

// File: rtl/vrb_voice_regs.sv
// Field registers of one voice.
// Decodes the seven addresses starting at BASE and holds the frequency,
// pulse width, control, attack/decay and sustain/release fields.
// Assumes at most one write per cycle. Reset is synchronous and active low.
module vrb_voice_regs
    import vrb_pkg::*;
#(
    parameter int BASE = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [FREQ_W-1:0] freq,
    output logic [PW_W-1:0]   pw,
    output logic [DATA_W-1:0] ctrl,
    output logic [DATA_W-1:0] atk_dec,
    output logic [DATA_W-1:0] sus_rel
);
    localparam int OFS_W = ADDR_W + 1;

    logic [OFS_W-1:0] ofs;
    logic             hit;

    // Offset of the address from this voice's base; the top bit flags an address below it.
    always_comb begin
        ofs = {1'b0, addr} - OFS_W'(BASE);
        hit = wr_en && !ofs[OFS_W-1] && (ofs[ADDR_W-1:0] < ADDR_W'(REGS_PER_VOICE));
    end

    // Load the addressed field on a write hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            freq    <= '0;
            pw      <= '0;
            ctrl    <= '0;
            atk_dec <= '0;
            sus_rel <= '0;
        end else if (hit) begin
            case (voice_ofs_e'(ofs[2:0]))
                OFS_FREQ_LO: freq[7:0]           <= wdata;
                OFS_FREQ_HI: freq[FREQ_W-1:8]    <= wdata[FREQ_W-9:0];
                OFS_PW_LO:   pw[7:0]             <= wdata;
                OFS_PW_HI:   pw[PW_W-1:8]        <= wdata[PW_W-9:0];
                OFS_CTRL:    ctrl                <= wdata;
                OFS_ATK_DEC: atk_dec             <= wdata;
                OFS_SUS_REL: sus_rel             <= wdata;
                default:     ;
            endcase
        end
    end
endmodule

// File: rtl/vrb_global_regs.sv
// Shared filter and volume field registers.
// Decodes the four addresses after the voice block and ignores all others.
// Reset is synchronous and active low.
module vrb_global_regs
    import vrb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [CUT_W-1:0]  cutoff,
    output logic [3:0]        resonance,
    output logic [3:0]        route_en,
    output logic              v3_mute,
    output logic [2:0]        filt_mode,
    output logic [3:0]        volume
);
    // Load the addressed shared field on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cutoff    <= '0;
            resonance <= '0;
            route_en  <= '0;
            v3_mute   <= 1'b0;
            filt_mode <= '0;
            volume    <= '0;
        end else if (wr_en) begin
            case (addr)
                A_CUT_LO: cutoff[CUT_LO_W-1:0] <= wdata[CUT_LO_W-1:0];
                A_CUT_HI: cutoff[CUT_W-1:CUT_LO_W] <= wdata;
                A_RES_ROUTE: begin
                    resonance <= wdata[7:4];
                    route_en  <= wdata[3:0];
                end
                A_MODE_VOL: begin
                    v3_mute   <= wdata[7];
                    filt_mode <= wdata[6:4];
                    volume    <= wdata[3:0];
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/vrb_last_byte.sv
// Holder for the last byte written to any address.
// Each write loads the byte and reloads a down-counter to HOLD_CYCLES. The
// byte clears on the edge where the counter steps from 1 to 0.
// Assumes HOLD_CYCLES >= 2. Reset is synchronous and active low.
module vrb_last_byte
    import vrb_pkg::*;
#(
    parameter int HOLD_CYCLES = HOLD_DEFAULT
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [DATA_W-1:0]     wdata,
    output logic [DATA_W-1:0]     hold_byte,
    output logic [CNT_W-1:0]      hold_cnt
);
    localparam int CNT_W = $clog2(HOLD_CYCLES + 1);

    // Capture on a write, count down otherwise, and clear at expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_byte <= '0;
            hold_cnt  <= '0;
        end else if (wr_en) begin
            hold_byte <= wdata;
            hold_cnt  <= CNT_W'(HOLD_CYCLES);
        end else if (hold_cnt == CNT_W'(1)) begin
            hold_byte <= '0;
            hold_cnt  <= '0;
        end else if (hold_cnt != '0) begin
            hold_cnt  <= hold_cnt - CNT_W'(1);
        end
    end
endmodule

// File: rtl/voice_reg_bus.sv
// Register bus of a three-voice synthesizer.
// Decodes byte writes into per-voice and shared field registers and serves
// reads: two zero locations, two live voice-3 values, and the expiring last
// written byte for every other address. Read data is combinational.
// Reset is synchronous and active low.
module voice_reg_bus
    import vrb_pkg::*;
#(
    parameter int HOLD_CYCLES = HOLD_DEFAULT
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [DATA_W-1:0]            wdata,
    input  logic                         wr_en,
    input  logic                         rd_en,
    output logic [DATA_W-1:0]            rd_data,
    input  logic [DATA_W-1:0]            osc3_in,
    input  logic [DATA_W-1:0]            env3_in,
    output logic [NUM_VOICES*FREQ_W-1:0] v_freq,
    output logic [NUM_VOICES*PW_W-1:0]   v_pw,
    output logic [NUM_VOICES*DATA_W-1:0] v_ctrl,
    output logic [NUM_VOICES*DATA_W-1:0] v_atk_dec,
    output logic [NUM_VOICES*DATA_W-1:0] v_sus_rel,
    output logic [CUT_W-1:0]             cutoff,
    output logic [3:0]                   resonance,
    output logic [3:0]                   route_en,
    output logic                         v3_mute,
    output logic [2:0]                   filt_mode,
    output logic [3:0]                   volume
);
    localparam int CNT_W = $clog2(HOLD_CYCLES + 1);

    logic [DATA_W-1:0] hold_byte;
    logic [CNT_W-1:0]  hold_cnt;

    for (genvar v = 0; v < NUM_VOICES; v++) begin : g_voice
        vrb_voice_regs #(.BASE(v * REGS_PER_VOICE)) u_voice (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en),
            .addr    (addr),
            .wdata   (wdata),
            .freq    (v_freq[v*FREQ_W +: FREQ_W]),
            .pw      (v_pw[v*PW_W +: PW_W]),
            .ctrl    (v_ctrl[v*DATA_W +: DATA_W]),
            .atk_dec (v_atk_dec[v*DATA_W +: DATA_W]),
            .sus_rel (v_sus_rel[v*DATA_W +: DATA_W])
        );
    end

    vrb_global_regs u_glob (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .cutoff    (cutoff),
        .resonance (resonance),
        .route_en  (route_en),
        .v3_mute   (v3_mute),
        .filt_mode (filt_mode),
        .volume    (volume)
    );

    vrb_last_byte #(.HOLD_CYCLES(HOLD_CYCLES)) u_last (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wdata     (wdata),
        .hold_byte (hold_byte),
        .hold_cnt  (hold_cnt)
    );

    // Select read data from the address; zero when no read is strobed.
    always_comb begin
        if (!rd_en) begin
            rd_data = '0;
        end else begin
            case (addr)
                A_ZERO0, A_ZERO1: rd_data = '0;
                A_OSC3:           rd_data = osc3_in;
                A_ENV3:           rd_data = env3_in;
                default:          rd_data = hold_byte;
            endcase
        end
    end
endmodule

// File: rtl/vrb_checker.sv
// Assertion checker for voice_reg_bus, attached by bind.
// Assumes the top runs with the default hold length.
module vrb_checker
    import vrb_pkg::*;
(
    input logic                         clk,
    input logic                         rst_n,
    input logic [ADDR_W-1:0]            addr,
    input logic [DATA_W-1:0]            wdata,
    input logic                         wr_en,
    input logic                         rd_en,
    input logic [DATA_W-1:0]            rd_data,
    input logic [DATA_W-1:0]            osc3_in,
    input logic [DATA_W-1:0]            env3_in,
    input logic [NUM_VOICES*FREQ_W-1:0] v_freq,
    input logic [NUM_VOICES*PW_W-1:0]   v_pw,
    input logic [NUM_VOICES*DATA_W-1:0] v_ctrl,
    input logic [CUT_W-1:0]             cutoff,
    input logic [3:0]                   volume,
    input logic [DATA_W-1:0]            hold_byte,
    input logic [HOLD_CNT_W-1:0]        hold_cnt
);
    // R8
    rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> rd_data == '0);

    // R7
    zero_loc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (addr == A_ZERO0 || addr == A_ZERO1)) |-> rd_data == '0);

    // R7
    osc_loc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == A_OSC3) |-> rd_data == osc3_in);

    // R7
    env_loc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == A_ENV3) |-> rd_data == env3_in);

    // R8
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> hold_byte == $past(wdata));

    // R9
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> hold_cnt == HOLD_CNT_W'(HOLD_DEFAULT));

    // R9
    countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && hold_cnt > HOLD_CNT_W'(1)) |=>
        (hold_cnt == $past(hold_cnt) - HOLD_CNT_W'(1) && $stable(hold_byte)));

    // R9
    expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && hold_cnt == HOLD_CNT_W'(1)) |=> (hold_byte == '0 && hold_cnt == '0));

    // R3
    fields_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(v_freq) && $stable(v_pw) && $stable(v_ctrl)
                    && $stable(cutoff) && $stable(volume)));

    // R6
    unused_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr > A_MODE_VOL) |=> ($stable(v_freq) && $stable(v_pw)
                    && $stable(v_ctrl) && $stable(cutoff) && $stable(volume)));
endmodule

bind voice_reg_bus vrb_checker u_vrb_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (addr),
    .wdata     (wdata),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .rd_data   (rd_data),
    .osc3_in   (osc3_in),
    .env3_in   (env3_in),
    .v_freq    (v_freq),
    .v_pw      (v_pw),
    .v_ctrl    (v_ctrl),
    .cutoff    (cutoff),
    .volume    (volume),
    .hold_byte (hold_byte),
    .hold_cnt  (hold_cnt)
);

// File: tb/voice_reg_bus_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench for voice_reg_bus. It sweeps every address with two
// data patterns, sweeps every read address and times the readback expiry.
module voice_reg_bus_tb_top;
    import vrb_pkg::*;

    localparam int HOLD = HOLD_DEFAULT;

    logic                         clk = 1'b0;
    logic                         rst_n = 1'b0;
    logic [ADDR_W-1:0]            addr = '0;
    logic [DATA_W-1:0]            wdata = '0;
    logic                         wr_en = 1'b0;
    logic                         rd_en = 1'b0;
    logic [DATA_W-1:0]            rd_data;
    logic [DATA_W-1:0]            osc3_in = '0;
    logic [DATA_W-1:0]            env3_in = '0;
    logic [NUM_VOICES*FREQ_W-1:0] v_freq;
    logic [NUM_VOICES*PW_W-1:0]   v_pw;
    logic [NUM_VOICES*DATA_W-1:0] v_ctrl;
    logic [NUM_VOICES*DATA_W-1:0] v_atk_dec;
    logic [NUM_VOICES*DATA_W-1:0] v_sus_rel;
    logic [CUT_W-1:0]             cutoff;
    logic [3:0]                   resonance;
    logic [3:0]                   route_en;
    logic                         v3_mute;
    logic [2:0]                   filt_mode;
    logic [3:0]                   volume;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Expected field values
    logic [15:0] e_freq [NUM_VOICES];
    logic [11:0] e_pw   [NUM_VOICES];
    logic [7:0]  e_ctrl [NUM_VOICES];
    logic [7:0]  e_ad   [NUM_VOICES];
    logic [7:0]  e_sr   [NUM_VOICES];
    logic [10:0] e_cut;
    logic [3:0]  e_res, e_route, e_vol;
    logic        e_mute;
    logic [2:0]  e_mode;
    logic [7:0]  e_last;

    always #5 clk = ~clk;

    voice_reg_bus dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
        .rd_en(rd_en), .rd_data(rd_data), .osc3_in(osc3_in), .env3_in(env3_in),
        .v_freq(v_freq), .v_pw(v_pw), .v_ctrl(v_ctrl), .v_atk_dec(v_atk_dec),
        .v_sus_rel(v_sus_rel), .cutoff(cutoff), .resonance(resonance),
        .route_en(route_en), .v3_mute(v3_mute), .filt_mode(filt_mode), .volume(volume)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic model_clear();
        for (int v = 0; v < NUM_VOICES; v++) begin
            e_freq[v] = '0; e_pw[v] = '0; e_ctrl[v] = '0; e_ad[v] = '0; e_sr[v] = '0;
        end
        e_cut = '0; e_res = '0; e_route = '0; e_vol = '0; e_mute = 1'b0;
        e_mode = '0; e_last = '0;
    endtask

    // Expected effect of one write, from the address map in R2, R4, R5, R6
    task automatic model_write(input int a, input logic [7:0] d);
        if (a < 21) begin
            case (a % 7)
                0: e_freq[a/7][7:0]  = d;
                1: e_freq[a/7][15:8] = d;
                2: e_pw[a/7][7:0]    = d;
                3: e_pw[a/7][11:8]   = d[3:0];
                4: e_ctrl[a/7]       = d;
                5: e_ad[a/7]         = d;
                default: e_sr[a/7]   = d;
            endcase
        end else if (a == 21) e_cut[2:0] = d[2:0];
        else if (a == 22) e_cut[10:3] = d;
        else if (a == 23) begin e_res = d[7:4]; e_route = d[3:0]; end
        else if (a == 24) begin e_mute = d[7]; e_mode = d[6:4]; e_vol = d[3:0]; end
        e_last = d;
    endtask

    task automatic compare_all(input string req);
        for (int v = 0; v < NUM_VOICES; v++) begin
            check(req, $sformatf("freq v%0d", v), 32'(v_freq[v*16 +: 16]), 32'(e_freq[v]));
            check(req, $sformatf("pw v%0d", v), 32'(v_pw[v*12 +: 12]), 32'(e_pw[v]));
            check(req, $sformatf("ctrl v%0d", v), 32'(v_ctrl[v*8 +: 8]), 32'(e_ctrl[v]));
            check(req, $sformatf("atk_dec v%0d", v), 32'(v_atk_dec[v*8 +: 8]), 32'(e_ad[v]));
            check(req, $sformatf("sus_rel v%0d", v), 32'(v_sus_rel[v*8 +: 8]), 32'(e_sr[v]));
        end
        check(req, "cutoff", 32'(cutoff), 32'(e_cut));
        check(req, "resonance/route", 32'({resonance, route_en}), 32'({e_res, e_route}));
        check(req, "mute/mode/volume", 32'({v3_mute, filt_mode, volume}),
              32'({e_mute, e_mode, e_vol}));
    endtask

    task automatic bus_write(input int a, input logic [7:0] d);
        @(negedge clk);
        addr = ADDR_W'(a); wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Advance one falling edge, then read combinationally 1 ns later
    task automatic peek(input string req, input int a, input logic [7:0] exp);
        @(negedge clk);
        addr = ADDR_W'(a); rd_en = 1'b1;
        #1;
        check(req, $sformatf("read addr %0h", a), 32'(rd_data), 32'(exp));
        rd_en = 1'b0;
    endtask

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        #1;
        // R1: reset state
        compare_all("R1");
        rd_en = 1'b1; addr = 5'h1D; #1;
        check("R1", "held byte after reset", 32'(rd_data), 32'h0);
        rd_en = 1'b0;
        rst_n = 1'b1;

        // R2 R3 R4 R5 R6: two-pattern write sweep over all 32 addresses
        for (int pass = 0; pass < 2; pass++) begin
            for (int a = 0; a < 32; a++) begin
                logic [7:0] d;
                d = 8'(a * 29 + 7);
                if (pass == 1) d = ~d;
                bus_write(a, d);
                model_write(a, d);
                #1;
                if (a >= 25) compare_all("R6");
                else if (a >= 23) compare_all("R5");
                else if (a >= 21) compare_all("R4");
                else compare_all("R2 R3");
                // R8: last written byte reads back at a general address
                peek("R8", 5'h1D, e_last);
            end
        end

        // R7 R8: every read address
        osc3_in = 8'hC3; env3_in = 8'h3C;
        bus_write(9, 8'h96); model_write(9, 8'h96);
        for (int r = 0; r < 32; r++) begin
            if (r == 25 || r == 26) peek("R7", r, 8'h00);
            else if (r == 27) peek("R7", r, osc3_in);
            else if (r == 28) peek("R7", r, env3_in);
            else peek("R8", r, 8'h96);
        end
        osc3_in = 8'h5E; env3_in = 8'hE5;
        peek("R7", 27, 8'h5E);
        peek("R7", 28, 8'hE5);
        // R8: no strobe gives zero
        @(negedge clk); addr = 5'h1D; rd_en = 1'b0; #1;
        check("R8", "rd_data with rd_en low", 32'(rd_data), 32'h0);

        // R9: expiry after a write to an unused address (also R6 on fields)
        bus_write(31, 8'hA7); model_write(31, 8'hA7);
        repeat (HOLD - 2) @(negedge clk);
        peek("R9", 5'h1D, 8'hA7);
        peek("R9", 5'h1D, 8'h00);
        #1; compare_all("R6");

        // R9: a later unused-address write restarts the window
        bus_write(30, 8'h4D);
        repeat (6000) @(negedge clk);
        bus_write(25, 8'h66); model_write(25, 8'h66);
        repeat (HOLD - 2) @(negedge clk);
        peek("R9", 5'h02, 8'h66);
        peek("R9", 5'h02, 8'h00);

        // R1: reset after activity
        bus_write(0, 8'hFF);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); #1;
        model_clear();
        compare_all("R1");
        rd_en = 1'b1; addr = 5'h00; #1;
        check("R1", "held byte after mid-run reset", 32'(rd_data), 32'h0);
        rd_en = 1'b0;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule